// File: doc/BRIEF.md
# Three-State Run Sequencer with Step Counter

This block is a small controller paired with a datapath. It has three control states: idle, run and done. It steers a binary step counter and two single-bit flags. A start pulse in idle zeroes the counter and begins a run. During the run the counter advances once per clock, and one flag follows a chosen counter bit. The run ends when two chosen counter bits are both high. The done state then raises a sticky completion flag and returns to idle.

The state is held in two flip-flops with a fixed binary code, and it is visible at the ports. A surrounding design, or a bench, can follow the sequence cycle by cycle. Every register update made in a state uses the values held at the start of that cycle. Reset is synchronous and active high.

Top module: `asm_seq_ctrl`

## Requirements
- R1: While reset is high, each clock edge puts the state at idle (code 00) and clears the counter, the tracking flag and the completion flag.
- R2: The state port shows only the codes idle = 00, run = 01 and done = 11. Code 10 never appears.
- R3: In idle with start low, the state stays idle, and the counter and tracking flag keep their values.
- R4: In idle with start high, the next clock zeroes the counter and moves the state to run.
- R5: In run, the counter increases by one on every clock.
- R6: In run, the tracking flag takes the value that counter bit 1 (weight 2) held at the start of the cycle.
- R7: In run, if counter bits 1 and 2 (weights 2 and 4) are both high at the start of the cycle, the next state is done. Otherwise the state stays in run.
- R8: In done, the next clock sets the completion flag and returns the state to idle, with the counter and tracking flag unchanged.
- R9: Once the completion flag is set, it stays set until reset.
- R10: The start input has no effect while the state is run or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled in idle |
| state_o | output | 2 | Current state code (00 idle, 01 run, 11 done) |
| count_o | output | CNT_W | Step counter value |
| flag_e_o | output | 1 | Tracking flag, follows counter bit 1 during run |
| flag_f_o | output | 1 | Sticky completion flag |

## Verification
The properties assume that start_i is a clean synchronous level that is known on every clock edge after reset. They also assume that reset is held for at least one edge before the first run, so the state register never starts from the unused code. The stimulus drives start_i only at the falling clock edge. It uses three patterns: start held high, a pseudo-random start stream, and isolated start pulses after idle gaps. Start is also driven high during run and done to show that it is ignored there. A reset in the middle of a run shows that the completion flag is cleared only by reset.

// File: rtl/asm_seq_pkg.sv
package asm_seq_pkg;

  // State codes; the two bits are the controller flip-flops.
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b11
  } seq_state_t;

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
  import asm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       exit_hit,
  output seq_state_t state
);

  logic in_idle;
  logic in_run;
  logic hi_next;
  logic lo_next;

  assign in_idle = (state == ST_IDLE);
  assign in_run  = (state == ST_RUN);

  // Per-bit next-state equations.
  assign hi_next = in_run & exit_hit;
  assign lo_next = (in_idle & start) | in_run;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= seq_state_t'({hi_next, lo_next});
  end

endmodule

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= bump(q);
  end

endmodule

// File: rtl/seq_flags.sv
module seq_flags (
  input  logic clk,
  input  logic rst,
  input  logic e_load,
  input  logic e_val,
  input  logic f_set,
  output logic e_q,
  output logic f_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      e_q <= 1'b0;
      f_q <= 1'b0;
    end else begin
      if (e_load) e_q <= e_val;
      if (f_set)  f_q <= 1'b1;
    end
  end

endmodule

// File: rtl/asm_seq_ctrl.sv
module asm_seq_ctrl
  import asm_seq_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int TRACK_BIT  = 1,
  parameter int EXIT_BIT_A = 1,
  parameter int EXIT_BIT_B = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic [1:0]       state_o,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_e_o,
  output logic             flag_f_o
);

  localparam logic [CNT_W-1:0] EXIT_MASK =
    CNT_W'((1 << EXIT_BIT_A) | (1 << EXIT_BIT_B));

  function automatic logic exit_cond(input logic [CNT_W-1:0] v);
    return (v & EXIT_MASK) == EXIT_MASK;
  endfunction

  seq_state_t state;

  // Named internal events for the checker.
  logic is_idle;
  logic is_run;
  logic is_done;
  logic run_start;
  logic exit_hit;

  assign is_idle   = (state == ST_IDLE);
  assign is_run    = (state == ST_RUN);
  assign is_done   = (state == ST_DONE);
  assign run_start = is_idle & start_i;
  assign exit_hit  = exit_cond(count_o);

  seq_fsm i_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start_i),
    .exit_hit (exit_hit),
    .state    (state)
  );

  seq_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk (clk),
    .rst (rst),
    .clr (run_start),
    .inc (is_run),
    .q   (count_o)
  );

  seq_flags i_flags (
    .clk    (clk),
    .rst    (rst),
    .e_load (is_run),
    .e_val  (count_o[TRACK_BIT]),
    .f_set  (is_done),
    .e_q    (flag_e_o),
    .f_q    (flag_f_o)
  );

  assign state_o = state;

endmodule

// File: rtl/asm_seq_chk.sv
module asm_seq_chk #(
  parameter int CNT_W     = 4,
  parameter int TRACK_BIT = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [1:0]       state_o,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_e_o,
  input logic             flag_f_o,
  input logic             exit_hit
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state_o == 2'b00 && count_o == '0 && !flag_e_o && !flag_f_o));

  // R2
  state_code_chk: assert property (@(posedge clk) disable iff (rst)
    state_o != 2'b10);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && !start_i) |=>
      (state_o == 2'b00 && $stable(count_o) && $stable(flag_e_o)));

  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && start_i) |=> (state_o == 2'b01 && count_o == '0));

  // R5
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01) |=> count_o == CNT_W'($past(count_o) + 1'b1));

  // R6
  track_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01) |=> flag_e_o == $past(count_o[TRACK_BIT]));

  // R7
  exit_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01 && exit_hit) |=> state_o == 2'b11);

  // R7
  exit_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01 && !exit_hit) |=> state_o == 2'b01);

  // R8
  done_return_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b11) |=>
      (state_o == 2'b00 && flag_f_o && $stable(count_o) && $stable(flag_e_o)));

  // R9
  f_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_f_o |=> flag_f_o);

endmodule

bind asm_seq_ctrl asm_seq_chk #(.CNT_W(CNT_W), .TRACK_BIT(TRACK_BIT)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .state_o  (state_o),
  .count_o  (count_o),
  .flag_e_o (flag_e_o),
  .flag_f_o (flag_f_o),
  .exit_hit (exit_hit)
);

// File: tb/test_asm_seq_ctrl.sv
module test_asm_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [1:0]   state_o;
  logic [W-1:0] count_o;
  logic         flag_e_o;
  logic         flag_f_o;

  int n_checks = 0;
  int n_fail   = 0;

  // Reference model registers.
  logic [1:0]   m_st;
  logic [W-1:0] m_a;
  logic         m_e;
  logic         m_f;
  logic [15:0]  lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  asm_seq_ctrl i_asm_seq_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .state_o  (state_o),
    .count_o  (count_o),
    .flag_e_o (flag_e_o),
    .flag_f_o (flag_f_o)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare the DUT with the model, then pick the next start value and
  // advance the model. The requirement tags follow the model state.
  task automatic step(input logic s);
    string rs;
    string ra;
    string re;
    check("R2", "code", int'(state_o == 2'b10), 0);
    check("R9", "flag_f", flag_f_o, m_f);
    start_i = s;
    if (m_st == 2'b00) begin
      rs = s ? "R4" : "R3";
      ra = rs;
      re = "R3";
    end else if (m_st == 2'b01) begin
      rs = s ? "R10" : "R7";
      ra = "R5";
      re = "R6";
    end else begin
      rs = s ? "R10" : "R8";
      ra = "R8";
      re = "R8";
    end
    @(negedge clk);
    case (m_st)
      2'b00: if (s) begin m_a = '0; m_st = 2'b01; end
      2'b01: begin
        // Exit when the weight-2 and weight-4 bits are both high.
        m_st = ((m_a / 2) % 2 == 1 && (m_a / 4) % 2 == 1) ? 2'b11 : 2'b01;
        m_e  = (m_a / 2) % 2 == 1;
        m_a  = W'(m_a + 1);
      end
      default: begin m_f = 1'b1; m_st = 2'b00; end
    endcase
    check(rs, "state", state_o, m_st);
    check(ra, "count", count_o, m_a);
    check(re, "flag_e", flag_e_o, m_e);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "state", state_o, 0);
    check("R1", "count", count_o, 0);
    check("R1", "flag_e", flag_e_o, 0);
    check("R1", "flag_f", flag_f_o, 0);
    rst = 1'b0;
    start_i = 1'b0;
    m_st = 2'b00; m_a = '0; m_e = 1'b0; m_f = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    do_reset();
    // Idle with start low: nothing moves.
    for (int i = 0; i < 5; i++) step(1'b0);
    // Pattern 1: start held high (also high during run and done).
    for (int i = 0; i < 60; i++) step(1'b1);
    // Pattern 2: pseudo-random start stream.
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0]);
    end
    // Pattern 3: isolated start pulses after idle gaps of growing length.
    for (int gap = 0; gap < 6; gap++) begin
      for (int i = 0; i < gap; i++) step(1'b0);
      step(m_st == 2'b00);
      for (int i = 0; i < 12; i++) step(1'b0);
    end
    // Reset during a run clears the sticky flag.
    step(1'b1);
    step(1'b0);
    step(1'b0);
    do_reset();
    check("R9", "flag_f after reset", flag_f_o, 0);
    for (int i = 0; i < 20; i++) step(1'b1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule